// File: doc/BRIEF.md
# Two-Wire Bus Read Master

This block is the master side of a two-wire serial bus that only reads. Software places a 7-bit target address on `slave_addr` and pulses `start_req`. The block then drives a START condition and sends the address with the direction bit set to read. It clocks in data bytes from the target. After each byte it drives an acknowledge bit whose value comes from the `ack_en` control level.

At each handover point it raises `irq` and holds the serial clock low. That handover comes after the address acknowledge slot and after every data acknowledge slot. Software reads `rx_data` and `addr_nack`, sets `ack_en` and `stop_req` for what comes next, and pulses `irq_clr`. The clear either starts the next byte or ends the transfer with a STOP condition.

Both bus lines are open-drain. The block only pulls them low (`scl_drive_low`, `sda_drive_low`) and reads the resolved data line on `sda_in`. Every high and every low phase of the clock lasts one half-bit period set by `half_div`.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset, and whenever `busy` is 0, both lines are released (`scl_drive_low`=0, `sda_drive_low`=0), with `irq`=0, `addr_nack`=0 and `rx_data`=0 after reset.
- R2: A `start_req` pulse while idle makes SDA go low while SCL stays released. This START hold lasts one half-bit period before SCL is first pulled low.
- R3: The first byte on the bus is `{slave_addr, 1'b1}` (bit 0 = 1 means read), sent most significant bit first, one bit per SCL high phase.
- R4: The master changes SDA only while SCL is low, except at START and STOP. SDA is stable throughout every SCL high phase of a bit.
- R5: The master samples the ninth-bit acknowledge of the address. A low line (ACK) raises `irq` with `addr_nack`=0. A high line (NACK) raises `irq` with `addr_nack`=1, and no data byte is received.
- R6: Data bits are sampled at the end of each SCL high phase, most significant bit first. At the `irq` that follows a data byte, `rx_data` holds that byte.
- R7: `ack_en` is captured at the end of the eighth data bit. If it is 1, the master pulls SDA low through the ninth clock (ACK). If it is 0, SDA is left released (NACK).
- R8: While `irq` is 1, SCL is held low and the transfer makes no progress until `irq_clr` is pulsed.
- R9: On `irq_clr`, one of two things happens. If `stop_req`=1, or if the address was not acknowledged, the block issues STOP (SDA rises while SCL is released) and `busy` returns to 0. Otherwise the next data byte begins.
- R10: Each SCL high phase of an address or data bit lasts exactly `half_div` clock cycles. A value of 0 is treated as 1.
- R11: `start_req` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div | input | DIV_W | Half-bit period in clock cycles (0 acts as 1) |
| slave_addr | input | 7 | Target address for the next transfer |
| start_req | input | 1 | Pulse: begin a read transfer when idle |
| stop_req | input | 1 | Level: the next `irq_clr` ends the transfer with STOP |
| ack_en | input | 1 | Level: 1 = ACK, 0 = NACK after a received byte |
| irq_clr | input | 1 | Pulse: clear `irq` and resume the bus |
| sda_in | input | 1 | Resolved level of the data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| rx_data | output | 8 | Last received data byte |
| irq | output | 1 | Event flag; the clock is held low while it is set |
| addr_nack | output | 1 | Address byte was not acknowledged |
| busy | output | 1 | A transfer is in progress |

## Verification
A wrong bit counter or a wrong direction bit shows at the ports within the first byte. The address seen on the bus is then wrong, or `irq` arrives after the wrong number of SCL pulses. A stale acknowledge capture or a wrong shift order shows at the very next `irq`, as a wrong line level in the ninth high phase or a wrong `rx_data`. A broken wait state lets SCL toggle while `irq` is set, which is visible on the next clock cycle. A divider fault changes the measured length of the next SCL high phase.

// File: rtl/i2c_rd_pkg.sv
// Shared types for the two-wire read master.
// Assumes: one 8-bit byte per transfer step and a 7-bit target address.
package i2c_rd_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    // Sequencer states; each timed state lasts one half-bit period.
    typedef enum logic [2:0] {
        ST_IDLE,     // bus released, waiting for a start request
        ST_START,    // SDA low while SCL high (START hold)
        ST_BIT_LO,   // SCL low, SDA set up for the current bit
        ST_BIT_HI,   // SCL high, SDA held, sampled at the end
        ST_WAIT,     // SCL held low until software clears irq
        ST_STOP_LO,  // SCL low, SDA low
        ST_STOP_HI,  // SCL high, SDA low (STOP setup)
        ST_FREE      // both released after STOP (bus free time)
    } rd_state_t;
endpackage

// File: rtl/i2c_rd_halfbit.sv
// Half-bit period timer.
// Produces a one-cycle tick every max(half_div,1) cycles while not cleared.
// Assumes: half_div is held stable during a transfer.
module i2c_rd_halfbit #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Terminal count: zero behaves like one cycle per half period.
    always_comb begin
        lim = (half_div == '0) ? '0 : half_div - 1'b1;
    end

    assign tick = !clr && (cnt == lim);

    // Count cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_rd_shifter.sv
// Byte shift register shared by the address and data phases.
// Loads the outgoing address byte, presents its MSB, and shifts the sampled line in at the LSB.
// Assumes: load and shift are never asserted together.
module i2c_rd_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] par,
    output logic         msb
);
    assign msb = par[W-1];

    // Parallel load or MSB-first shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par <= '0;
        end else if (load) begin
            par <= load_val;
        end else if (shift) begin
            par <= {par[W-2:0], ser_in};
        end
    end
endmodule

// File: rtl/i2c_rd_seq.sv
// Bit and byte sequencer of the read master.
// Walks START, address byte, acknowledge slots, data bytes and STOP.
// Holds SCL low while the event flag is set.
// Assumes: tick comes from a timer that is cleared in IDLE and WAIT,
// so every timed state lasts exactly one half-bit period.
module i2c_rd_seq
    import i2c_rd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              ack_en,
    input  logic              irq_clr,
    input  logic              sda_in,
    input  logic              sh_msb,
    input  logic [BYTE_W-1:0] sh_par,
    output logic              sh_load,
    output logic              sh_shift,
    output logic              div_clr,
    output rd_state_t         state,
    output logic              scl_low,
    output logic              sda_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq,
    output logic              addr_nack,
    output logic              busy
);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic             is_addr;
    logic             ack_q;

    assign busy     = (state != ST_IDLE);
    assign div_clr  = (state == ST_IDLE) || (state == ST_WAIT);
    assign sh_load  = (state == ST_IDLE) && start_req;
    assign sh_shift = (state == ST_BIT_HI) && tick && (bit_cnt != ACK_SLOT);

    // Decode line drives from the registered state.
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (state)
            ST_START:   sda_low = 1'b1;
            ST_BIT_LO, ST_BIT_HI: begin
                scl_low = (state == ST_BIT_LO);
                if (bit_cnt == ACK_SLOT) begin
                    sda_low = !is_addr && ack_q;
                end else begin
                    sda_low = is_addr && !sh_msb;
                end
            end
            ST_WAIT:    scl_low = 1'b1;
            ST_STOP_LO: begin
                scl_low = 1'b1;
                sda_low = 1'b1;
            end
            ST_STOP_HI: sda_low = 1'b1;
            default: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
        endcase
    end

    // Main sequencer: state, bit position, results and event flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            is_addr   <= 1'b0;
            ack_q     <= 1'b0;
            rx_data   <= '0;
            irq       <= 1'b0;
            addr_nack <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state     <= ST_START;
                        is_addr   <= 1'b1;
                        bit_cnt   <= '0;
                        addr_nack <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick) state <= ST_BIT_LO;
                end
                ST_BIT_LO: begin
                    if (tick) state <= ST_BIT_HI;
                end
                ST_BIT_HI: begin
                    if (tick) begin
                        if (bit_cnt == ACK_SLOT) begin
                            if (is_addr) begin
                                addr_nack <= sda_in;
                            end else begin
                                rx_data <= sh_par;
                            end
                            irq   <= 1'b1;
                            state <= ST_WAIT;
                        end else begin
                            if (bit_cnt == LAST_BIT) ack_q <= ack_en;
                            bit_cnt <= bit_cnt + 1'b1;
                            state   <= ST_BIT_LO;
                        end
                    end
                end
                ST_WAIT: begin
                    if (irq_clr) begin
                        irq <= 1'b0;
                        if (stop_req || addr_nack) begin
                            state <= ST_STOP_LO;
                        end else begin
                            state   <= ST_BIT_LO;
                            is_addr <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                end
                ST_STOP_LO: begin
                    if (tick) state <= ST_STOP_HI;
                end
                ST_STOP_HI: begin
                    if (tick) state <= ST_FREE;
                end
                default: begin
                    if (tick) state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_rd_master.sv
// Two-wire bus read master (top).
// Ties together the half-bit timer, the byte shifter and the sequencer.
// Assumes: open-drain pads outside; sda_in is the resolved, synchronised line level;
// the target does not stretch the clock and there is no other master.
module i2c_rd_master
    import i2c_rd_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              ack_en,
    input  logic              irq_clr,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq,
    output logic              addr_nack,
    output logic              busy
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic              tick;
    logic              div_clr;
    logic              sh_load;
    logic              sh_shift;
    logic              sh_msb;
    logic [BYTE_W-1:0] sh_par;
    rd_state_t         seq_state;

    i2c_rd_halfbit #(.DIV_W(DIV_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (div_clr),
        .half_div (half_div),
        .tick     (tick)
    );

    i2c_rd_shifter #(.W(BYTE_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val ({slave_addr, 1'b1}),
        .shift    (sh_shift),
        .ser_in   (sda_in),
        .par      (sh_par),
        .msb      (sh_msb)
    );

    i2c_rd_seq #(.CNT_W(CNT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_req (start_req),
        .stop_req  (stop_req),
        .ack_en    (ack_en),
        .irq_clr   (irq_clr),
        .sda_in    (sda_in),
        .sh_msb    (sh_msb),
        .sh_par    (sh_par),
        .sh_load   (sh_load),
        .sh_shift  (sh_shift),
        .div_clr   (div_clr),
        .state     (seq_state),
        .scl_low   (scl_drive_low),
        .sda_low   (sda_drive_low),
        .rx_data   (rx_data),
        .irq       (irq),
        .addr_nack (addr_nack),
        .busy      (busy)
    );
endmodule

// File: rtl/i2c_rd_master_chk.sv
// Property checker for the read master, bound to every instance of the top.
// Assumes: the sequencer state is visible as seq_state inside the top.
module i2c_rd_master_chk
    import i2c_rd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input rd_state_t         state,
    input logic              scl_drive_low,
    input logic              sda_drive_low,
    input logic [BYTE_W-1:0] rx_data,
    input logic              irq,
    input logic              irq_clr,
    input logic              addr_nack,
    input logic              busy
);
    // R1: an idle block leaves both lines released.
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low));

    // R2: the START hold has SDA low and SCL released.
    p_start_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> (sda_drive_low && !scl_drive_low));

    // R4: SDA does not move during a bit's high phase.
    p_sda_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && $past(state) == ST_BIT_HI) |-> $stable(sda_drive_low));

    // R5: an address NACK is always reported with the event flag.
    p_nack_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_nack) |-> irq);

    // R8: the clock is held low while the flag is set.
    p_irq_holds_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> scl_drive_low);

    // R8: without a clear, the flag stays and the received byte does not move.
    p_wait_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> (irq && $stable(rx_data)));
endmodule

bind i2c_rd_master i2c_rd_master_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (seq_state),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .rx_data       (rx_data),
    .irq           (irq),
    .irq_clr       (irq_clr),
    .addr_nack     (addr_nack),
    .busy          (busy)
);

// File: tb/i2c_rd_master_tb_top.sv
// Self-checking bench: a behavioural target on the bus, directed corner cases and seeded random transfers.
module i2c_rd_master_tb_top;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] half_div = '0;
    logic [6:0]       slave_addr = '0;
    logic             start_req = 1'b0;
    logic             stop_req = 1'b0;
    logic             ack_en = 1'b0;
    logic             irq_clr = 1'b0;
    logic             slave_low = 1'b0;
    logic             sda_line;
    logic             scl_drive_low;
    logic             sda_drive_low;
    logic [7:0]       rx_data;
    logic             irq;
    logic             addr_nack;
    logic             busy;

    int total = 0;
    int bad = 0;

    assign sda_line = !(sda_drive_low || slave_low);

    always #2.5 clk = !clk;

    i2c_rd_master #(.DIV_W(DIV_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_div      (half_div),
        .slave_addr    (slave_addr),
        .start_req     (start_req),
        .stop_req      (stop_req),
        .ack_en        (ack_en),
        .irq_clr       (irq_clr),
        .sda_in        (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .rx_data       (rx_data),
        .irq           (irq),
        .addr_nack     (addr_nack),
        .busy          (busy)
    );

    // Record one check and report it if it failed.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected first byte on the bus: address then read bit.
    function automatic logic [7:0] exp_addr_byte(input logic [6:0] a);
        return {a, 1'b1};
    endfunction

    // Effective half-bit length.
    function automatic int eff_half(input int h);
        return (h == 0) ? 1 : h;
    endfunction

    // Wait out one SCL high phase; return its length and SDA at its first and last cycle.
    task automatic wait_high(output int hl, output logic first, output logic last);
        do @(negedge clk); while (scl_drive_low);
        hl = 0;
        first = sda_line;
        last = sda_line;
        while (!scl_drive_low) begin
            hl++;
            last = sda_line;
            @(negedge clk);
        end
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // One full read transfer with the bus target modelled here.
    task automatic do_read(input logic [6:0] a, input int h, input bit tgt_ack,
                           input int nbytes, input logic [3:0][7:0] data,
                           input logic [3:0] acks, input bit try_restart);
        int hl;
        int k;
        logic f;
        logic l;
        logic [7:0] got;
        bit stable_ok;
        bit len_ok;
        half_div = DIV_W'(h);
        slave_addr = a;
        stop_req = 1'b0;
        slave_low = 1'b0;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        chk(!scl_drive_low && sda_drive_low, "R2 start shape", {scl_drive_low, sda_drive_low}, 2'b01);
        k = 0;
        while (!scl_drive_low) begin
            k++;
            @(negedge clk);
        end
        chk(k == eff_half(h), "R2 start hold length", k, eff_half(h));
        got = '0;
        stable_ok = 1'b1;
        len_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_high(hl, f, l);
            got = {got[6:0], f};
            if (f != l) stable_ok = 1'b0;
            if (hl != eff_half(h)) len_ok = 1'b0;
        end
        chk(got == exp_addr_byte(a), "R3 address byte", got, exp_addr_byte(a));
        chk(stable_ok, "R4 SDA stable while SCL high", stable_ok, 1);
        chk(len_ok, "R10 high phase length", len_ok, 1);
        slave_low = tgt_ack;
        wait_high(hl, f, l);
        wait_irq();
        chk(addr_nack == !tgt_ack, "R5 address acknowledge status", addr_nack, !tgt_ack);
        chk(scl_drive_low, "R8 SCL held low on irq", scl_drive_low, 1);
        if (!tgt_ack) begin
            slave_low = 1'b0;
            stop_req = 1'b0;
        end else begin
            for (int b = 0; b < nbytes; b++) begin
                slave_low = !data[b][7];
                ack_en = acks[b];
                if (try_restart && b == 0) begin
                    start_req = 1'b1;
                    @(negedge clk);
                    start_req = 1'b0;
                    repeat (3) @(negedge clk);
                    chk(irq && busy && scl_drive_low, "R11 start ignored while busy",
                        {irq, busy, scl_drive_low}, 3'b111);
                end
                repeat (2) @(negedge clk);
                chk(irq && scl_drive_low, "R8 no progress before clear", {irq, scl_drive_low}, 2'b11);
                pulse_clr();
                for (int i = 0; i < 8; i++) begin
                    wait_high(hl, f, l);
                    slave_low = (i < 7) ? !data[b][6 - i] : 1'b0;
                end
                wait_high(hl, f, l);
                chk(f == !acks[b], "R7 acknowledge level from ack_en", f, !acks[b]);
                wait_irq();
                chk(rx_data == data[b], "R6 received byte", rx_data, data[b]);
            end
            stop_req = 1'b1;
        end
        pulse_clr();
        do @(negedge clk); while (scl_drive_low);
        chk(sda_drive_low, "R9 STOP setup with SDA low", sda_drive_low, 1);
        while (sda_drive_low) @(negedge clk);
        chk(!scl_drive_low && sda_line, "R9 SDA rises with SCL released", {scl_drive_low, sda_line}, 2'b01);
        while (busy) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low && !irq, "R1 released after stop",
            {scl_drive_low, sda_drive_low, irq}, 0);
        stop_req = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0][7:0] d;
        int unsigned s;
        s = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low && !irq && !busy && !addr_nack && rx_data == 0,
            "R1 reset state", {scl_drive_low, sda_drive_low, irq, busy, addr_nack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !scl_drive_low, "R1 idle after reset", busy, 0);
        // Directed: alternating bits, ACK then NACK, restart attempt while busy.
        d = {8'h00, 8'h00, 8'h5A, 8'hA5};
        do_read(7'h55, 2, 1'b1, 2, d, 4'b0001, 1'b1);
        // Directed: zero divider acts as one cycle; extreme bytes.
        d = {8'h00, 8'h00, 8'h00, 8'hFF};
        do_read(7'h7F, 0, 1'b1, 1, d, 4'b0000, 1'b0);
        d = {8'h00, 8'h00, 8'h80, 8'h01};
        do_read(7'h00, 1, 1'b1, 2, d, 4'b0011, 1'b0);
        // Directed: address not acknowledged, clear with stop_req low still stops.
        do_read(7'h2C, 3, 1'b0, 0, d, 4'b0000, 1'b0);
        // Seeded random transfers.
        for (int t = 0; t < 12; t++) begin
            logic [6:0] a;
            int h;
            int n;
            bit ak;
            a = 7'($urandom);
            h = int'($urandom_range(0, 4));
            n = int'($urandom_range(1, 3));
            ak = ($urandom_range(0, 9) != 0);
            for (int b = 0; b < 4; b++) d[b] = 8'($urandom);
            do_read(a, h, ak, n, d, 4'($urandom), 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule